// File: doc/BRIEF.md
# Self-identification record collector

After every bus reset, the nodes of a serial bus announce themselves with short self-identification packets. Each packet is one information quadlet followed by its bitwise complement. This block takes those quadlets from a 32-bit valid/ready stream and checks each pair. It then builds a single framed record on a valid/ready FIFO write stream. The record opens with the constant header quadlet `32'h0000_00E0`. Every pair that passes the check follows the header, the information quadlet first and its complement second. The record closes with a quadlet that carries the link acknowledge code in its low bits and zeros above it.

The block also follows the extended-packet chain of each node. A node with many ports sends a base packet (bit 23 = 0) and then one or two extended packets (bit 23 = 1). Each extended packet holds a sequence number in bits 22:20 and repeats the physical ID in bits 29:24. Bit 0 means "another packet of this node follows", and bits 31:30 must be `2'b10`. The block counts the base packets it accepts and exposes that count as the number of nodes. A bus-reset pulse empties the record state, the counter and both error flags.

Back-pressure works as follows. A word on the output is held with its data unchanged until `out_ready` is high at a clock edge. While any word of the record is still waiting to be written, `in_ready` is low. The collector therefore never drops an input quadlet that it has accepted for lack of room.

Top module: `selfid_gather`

## Requirements
- R1: The first word written after a bus reset or power-on reset is always `32'h0000_00E0`. It is written even when no self-ID pair arrives.
- R2: A pair whose second quadlet equals the bitwise complement of the first is written right after the header or the previous pair, the first quadlet before the complement.
- R3: If the second quadlet of a pair is not the exact complement of the first, neither quadlet is written and `err_inverse` sets and stays set until the next bus reset.
- R4: A pulse on `sid_done` causes one closing word `{zeros, ack_code}` to be written as the last word of the record. `ack_code` is sampled at the strobe. Any quadlets or strobes after it write nothing until a bus reset.
- R5: If `sid_done` arrives before any pair, the record is the header word followed by the closing word, and nothing else.
- R6: A pair is a sequence error, and sets the sticky `err_sequence`, in any of these cases. Bits 31:30 are not `2'b10`. After a packet with bit 0 set, the next packet is not an extended packet with the same bits 29:24 and with bits 22:20 one greater than the previous extended packet (0 after a base packet). An extended packet arrives when none was announced. `sid_done` arrives while an extended packet is still owed. Sequence errors do not stop the pair from being written.
- R7: `node_count` rises by one for each accepted pair whose bit 23 is 0, and holds at its maximum value.
- R8: A `bus_rst` pulse clears `node_count`, both error flags and any words not yet written, and then starts a new record.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` is low while the record has words waiting.
- R10: If `sid_done` arrives while a first quadlet is held without its complement, that quadlet is dropped and `err_inverse` sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | Bus-reset pulse, starts a new record |
| in_valid | input | 1 | Self-ID quadlet present |
| in_ready | output | 1 | Collector can take a quadlet |
| in_data | input | 32 | Self-ID quadlet |
| sid_done | input | 1 | End of self-identification strobe |
| ack_code | input | ACK_W | Acknowledge code for the closing word |
| out_valid | output | 1 | FIFO write request |
| out_ready | input | 1 | FIFO can take the word |
| out_data | output | 32 | FIFO write data |
| err_inverse | output | 1 | Sticky complement-check error |
| err_sequence | output | 1 | Sticky extended-chain error |
| node_count | output | NODE_W | Base packets accepted since bus reset |

## Verification
When the second quadlet of a pair is accepted at clock edge k, the header (or the first quadlet) is on `out_data` from edge k. `node_count` and both error flags have also changed after edge k. A `sid_done` sampled at edge k is recorded at that edge, and the closing word is loaded at edge k+1 once the output is idle. The bench sets inputs on falling edges and records each handshake on the falling edge before the rising edge that completes it. It reads flags and counts only after a drain period that is longer than any of these latencies. It checks that stalled words stay unchanged on every falling edge that follows a stall.

// File: rtl/selfid_pkg.sv
package selfid_pkg;
  localparam int unsigned QW = 32;
  localparam logic [QW-1:0] REC_HEADER = 32'h0000_00E0;
  localparam logic [1:0] SID_TAG = 2'b10;
  localparam int unsigned PHY_W = 6;
  localparam int unsigned SEQ_W = 3;
  localparam int unsigned REC_DEPTH = 3;   // header + pair is the longest burst
  localparam int unsigned REC_CW = $clog2(REC_DEPTH + 1);

  typedef struct packed {
    logic [1:0]       tag;
    logic [PHY_W-1:0] phy;
    logic             ext;
    logic [SEQ_W-1:0] seq;
    logic [18:0]      body;
    logic             more;
  } sid_word_t;
endpackage

// File: rtl/sid_pair_check.sv
module sid_pair_check
  import selfid_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          in_fire,
  input  logic [QW-1:0] in_data,
  input  logic          done,
  output logic          pair_ok,
  output logic [QW-1:0] pair_a,
  output logic [QW-1:0] pair_b,
  output logic          err_inv
);
  logic          have_a;
  logic [QW-1:0] a_q;
  logic          take, match;

  assign take    = in_fire && en;
  assign match   = (in_data == ~a_q);
  assign pair_ok = take && have_a && match;
  assign pair_a  = a_q;
  assign pair_b  = in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_a  <= 1'b0;
      a_q     <= '0;
      err_inv <= 1'b0;
    end else if (clr) begin
      have_a  <= 1'b0;
      a_q     <= '0;
      err_inv <= 1'b0;
    end else if (take) begin
      if (!have_a) begin
        a_q    <= in_data;
        have_a <= 1'b1;
      end else begin
        have_a <= 1'b0;
        if (!match) err_inv <= 1'b1;
      end
    end else if (done && en && have_a) begin
      // orphaned first quadlet at end of phase
      have_a  <= 1'b0;
      err_inv <= 1'b1;
    end
  end
endmodule

// File: rtl/sid_chain_track.sv
module sid_chain_track
  import selfid_pkg::*;
#(
  parameter int unsigned NODE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pair_ok,
  input  logic [1:0]       w_tag,
  input  logic [PHY_W-1:0] w_phy,
  input  logic             w_ext,
  input  logic [SEQ_W-1:0] w_seq,
  input  logic             w_more,
  input  logic             done,
  output logic             seq_err,
  output logic [NODE_W-1:0] node_count
);
  localparam logic [NODE_W-1:0] CNT_MAX = {NODE_W{1'b1}};

  logic             exp_ext;
  logic [PHY_W-1:0] exp_phy;
  logic [SEQ_W-1:0] exp_seq;
  logic             bad;

  always_comb begin
    bad = (w_tag != SID_TAG);
    if (exp_ext) begin
      if (!w_ext || (w_phy != exp_phy) || (w_seq != exp_seq)) bad = 1'b1;
    end else if (w_ext) begin
      bad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_ext    <= 1'b0;
      exp_phy    <= '0;
      exp_seq    <= '0;
      seq_err    <= 1'b0;
      node_count <= '0;
    end else if (clr) begin
      exp_ext    <= 1'b0;
      exp_phy    <= '0;
      exp_seq    <= '0;
      seq_err    <= 1'b0;
      node_count <= '0;
    end else if (pair_ok) begin
      if (bad) seq_err <= 1'b1;
      if (!w_ext && (node_count != CNT_MAX)) node_count <= node_count + 1'b1;
      exp_ext <= w_more;
      exp_phy <= w_phy;
      exp_seq <= w_ext ? w_seq + 1'b1 : '0;
    end else if (done && exp_ext) begin
      seq_err <= 1'b1;
      exp_ext <= 1'b0;
    end
  end
endmodule

// File: rtl/sid_emit_queue.sv
module sid_emit_queue
  import selfid_pkg::*;
#(
  parameter int unsigned ACK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pair_ok,
  input  logic [QW-1:0]    pair_a,
  input  logic [QW-1:0]    pair_b,
  input  logic             done,
  input  logic [ACK_W-1:0] ack_code,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [QW-1:0]    out_data,
  output logic             busy,
  output logic             sealed
);
  logic [QW-1:0]     slot [REC_DEPTH];
  logic [REC_CW-1:0] cnt;
  logic              hdr_sent, done_pend, closed;
  logic [ACK_W-1:0]  ack_q;
  logic [QW-1:0]     ack_word;

  assign ack_word  = {{(QW-ACK_W){1'b0}}, ack_q};
  assign busy      = (cnt != '0);
  assign out_valid = busy;
  assign out_data  = slot[0];
  assign sealed    = closed || done_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      hdr_sent  <= 1'b0;
      done_pend <= 1'b0;
      closed    <= 1'b0;
      ack_q     <= '0;
      for (int i = 0; i < REC_DEPTH; i++) slot[i] <= '0;
    end else if (clr) begin
      cnt       <= '0;
      hdr_sent  <= 1'b0;
      done_pend <= 1'b0;
      closed    <= 1'b0;
    end else begin
      if (done && !closed && !done_pend) begin
        done_pend <= 1'b1;
        ack_q     <= ack_code;
      end
      if (busy) begin
        if (out_ready) begin
          for (int i = 0; i < REC_DEPTH - 1; i++) slot[i] <= slot[i+1];
          cnt <= cnt - 1'b1;
        end
      end else if (pair_ok) begin
        hdr_sent <= 1'b1;
        if (!hdr_sent) begin
          slot[0] <= REC_HEADER;
          slot[1] <= pair_a;
          slot[2] <= pair_b;
          cnt     <= REC_CW'(3);
        end else begin
          slot[0] <= pair_a;
          slot[1] <= pair_b;
          cnt     <= REC_CW'(2);
        end
      end else if (done_pend) begin
        hdr_sent  <= 1'b1;
        done_pend <= 1'b0;
        closed    <= 1'b1;
        if (!hdr_sent) begin
          slot[0] <= REC_HEADER;
          slot[1] <= ack_word;
          cnt     <= REC_CW'(2);
        end else begin
          slot[0] <= ack_word;
          cnt     <= REC_CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/selfid_gather.sv
module selfid_gather
  import selfid_pkg::*;
#(
  parameter int unsigned ACK_W  = 4,
  parameter int unsigned NODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              sid_done,
  input  logic [ACK_W-1:0]  ack_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              err_inverse,
  output logic              err_sequence,
  output logic [NODE_W-1:0] node_count
);
  logic          busy, sealed, pair_ok, in_fire;
  logic [QW-1:0] pair_a, pair_b;
  sid_word_t     pw;

  assign in_ready = !busy;
  assign in_fire  = in_valid && in_ready;
  assign pw       = pair_a;

  sid_pair_check u_pair (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .en(!sealed),
    .in_fire(in_fire), .in_data(in_data), .done(sid_done),
    .pair_ok(pair_ok), .pair_a(pair_a), .pair_b(pair_b), .err_inv(err_inverse)
  );

  sid_chain_track #(.NODE_W(NODE_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .pair_ok(pair_ok),
    .w_tag(pw.tag), .w_phy(pw.phy), .w_ext(pw.ext), .w_seq(pw.seq), .w_more(pw.more),
    .done(sid_done && !sealed), .seq_err(err_sequence), .node_count(node_count)
  );

  sid_emit_queue #(.ACK_W(ACK_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .pair_ok(pair_ok),
    .pair_a(pair_a), .pair_b(pair_b), .done(sid_done), .ack_code(ack_code),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .busy(busy), .sealed(sealed)
  );
endmodule

// File: rtl/selfid_gather_chk.sv
module selfid_gather_chk #(
  parameter int unsigned NODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic              err_inverse,
  input logic              err_sequence,
  input logic [NODE_W-1:0] node_count
);
  logic wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrote <= 1'b0;
    else if (bus_rst) wrote <= 1'b0;
    else if (out_valid && out_ready) wrote <= 1'b1;
  end

  a_r1_header_first: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !wrote && !bus_rst) |-> (out_data == 32'h0000_00E0));

  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !bus_rst) |=> (out_valid && $stable(out_data)));

  a_r3_inv_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_inverse && !bus_rst) |=> err_inverse);

  a_r6_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sequence && !bus_rst) |=> err_sequence);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst |=> ((node_count == $past(node_count)) || (node_count == $past(node_count) + 1'b1)));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (node_count == '0 && !err_inverse && !err_sequence && !out_valid));
endmodule

bind selfid_gather selfid_gather_chk #(.NODE_W(NODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .err_inverse(err_inverse),
  .err_sequence(err_sequence), .node_count(node_count)
);

// File: tb/sim_selfid_gather.sv
module sim_selfid_gather;
  localparam int CLK_P = 10;
  localparam int NW = 6;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
  logic in_valid = 1'b0, in_ready, sid_done = 1'b0, out_valid, out_ready = 1'b0;
  logic [31:0] in_data = '0, out_data;
  logic [AW-1:0] ack_code = '0;
  logic err_inverse, err_sequence;
  logic [NW-1:0] node_count;

  always #(CLK_P/2) clk = ~clk;

  selfid_gather #(.ACK_W(AW), .NODE_W(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sid_done(sid_done), .ack_code(ack_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .err_inverse(err_inverse),
    .err_sequence(err_sequence), .node_count(node_count)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] rec [256];
  logic [31:0] expw [256];
  int rec_n = 0, exp_n = 0;
  int rmode = 0;
  logic [7:0] lfsr = 8'h5A;
  logic prev_stall = 1'b0;
  logic [31:0] prev_data = '0;
  int stall_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, ex);
    end
  endtask

  // output side: choose ready, check stall hold (R9), record handshakes
  always @(negedge clk) begin
    if (prev_stall && !bus_rst && (!out_valid || out_data != prev_data)) stall_bad++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = ~out_ready;
      default: out_ready = lfsr[0];
    endcase
    if (out_valid && out_ready && !bus_rst && rec_n < 256) begin
      rec[rec_n] = out_data;
      rec_n++;
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  end

  function automatic logic [31:0] mk(input int id, input bit ext, input int n, input bit more);
    logic [18:0] body;
    body = 19'(id * 977 + n * 31 + 5);
    return {2'b10, 6'(id), ext, (ext ? 3'(n) : 3'(id)), body, more};
  endfunction

  task automatic send_q(input logic [31:0] q);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = q;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_exp(input logic [31:0] q);
    expw[exp_n] = q;
    exp_n++;
  endtask

  task automatic good_pair(input logic [31:0] q);
    send_q(q);
    send_q(~q);
    push_exp(q);
    push_exp(~q);
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk);
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
    rec_n = 0;
    exp_n = 0;
    push_exp(32'h0000_00E0);
  endtask

  task automatic finish_rec(input logic [AW-1:0] a);
    @(negedge clk);
    sid_done = 1'b1;
    ack_code = a;
    @(negedge clk);
    sid_done = 1'b0;
    ack_code = ~a;
    push_exp({28'd0, a});
    repeat (40) @(negedge clk);
  endtask

  task automatic cmp_rec(input string what);
    chk(rec_n == exp_n, {what, " R4 word count"}, 32'(rec_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      if (i == 0) chk(rec[i] == expw[i], {what, " R1 header"}, rec[i], expw[i]);
      else if (i == exp_n - 1) chk(rec[i] == expw[i], {what, " R4 ack word"}, rec[i], expw[i]);
      else chk(rec[i] == expw[i], {what, " R2 pair word"}, rec[i], expw[i]);
    end
  endtask

  task automatic flags(input string what, input bit ei, input bit es, input int nc);
    chk(err_inverse == ei, {what, " R3 err_inverse"}, 32'(err_inverse), 32'(ei));
    chk(err_sequence == es, {what, " R6 err_sequence"}, 32'(err_sequence), 32'(es));
    chk(node_count == NW'(nc), {what, " R7 node_count"}, 32'(node_count), 32'(nc));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 reset in_ready", 32'(in_ready), 1);
    flags("reset", 0, 0, 0);

    // sweep: nodes 0..3, each with (k%3)+1 packets, three ready patterns
    for (int m = 0; m < 3; m++) begin
      for (int nodes = 0; nodes < 4; nodes++) begin
        rmode = m;
        pulse_bus_rst();
        for (int k = 0; k < nodes; k++) begin
          int np;
          np = (k % 3) + 1;
          for (int p = 0; p < np; p++) good_pair(mk(k + 1, p > 0, p - 1, p < np - 1));
        end
        finish_rec(AW'(nodes * 3 + m + 1));
        if (nodes == 0) cmp_rec("R5 lone node");
        else cmp_rec("sweep");
        flags("sweep", 0, 0, nodes);
      end
    end

    // R4: quadlets and strobes after the closing word are ignored
    send_q(mk(9, 0, 0, 0));
    send_q(~mk(9, 0, 0, 0));
    @(negedge clk); sid_done = 1'b1; @(negedge clk); sid_done = 1'b0;
    repeat (20) @(negedge clk);
    cmp_rec("R4 after close");
    chk(node_count == NW'(3), "R4 count after close", 32'(node_count), 3);

    // R3: broken complement dropped
    rmode = 2;
    pulse_bus_rst();
    good_pair(mk(1, 0, 0, 0));
    send_q(mk(2, 0, 0, 0));
    send_q(~mk(2, 0, 0, 0) ^ 32'h0000_0100);
    good_pair(mk(3, 0, 0, 0));
    finish_rec(AW'(7));
    cmp_rec("R3 mismatch");
    flags("R3 mismatch", 1, 0, 2);

    // R10: orphan quadlet at the end strobe
    pulse_bus_rst();
    good_pair(mk(4, 0, 0, 0));
    send_q(mk(5, 0, 0, 0));
    finish_rec(AW'(2));
    cmp_rec("R10 orphan");
    flags("R10 orphan", 1, 0, 1);

    // R6: wrong sequence number
    pulse_bus_rst();
    good_pair(mk(6, 0, 0, 1));
    good_pair(mk(6, 1, 1, 0));
    finish_rec(AW'(1));
    cmp_rec("R6 bad n");
    flags("R6 bad n", 0, 1, 1);

    // R6: wrong physical ID on extended packet
    pulse_bus_rst();
    good_pair(mk(6, 0, 0, 1));
    good_pair(mk(7, 1, 0, 0));
    finish_rec(AW'(3));
    flags("R6 bad id", 0, 1, 1);

    // R6: unannounced extended packet
    pulse_bus_rst();
    good_pair(mk(8, 1, 0, 0));
    finish_rec(AW'(4));
    cmp_rec("R6 stray ext");
    flags("R6 stray ext", 0, 1, 0);

    // R6: end strobe while an extended packet is owed
    pulse_bus_rst();
    good_pair(mk(8, 0, 0, 1));
    finish_rec(AW'(5));
    flags("R6 owed ext", 0, 1, 1);

    // R6: bad tag bits
    pulse_bus_rst();
    good_pair(mk(8, 0, 0, 0) & 32'h7FFF_FFFF);
    finish_rec(AW'(6));
    flags("R6 bad tag", 0, 1, 1);

    // R8: bus reset in the middle of a record
    rmode = 1;
    pulse_bus_rst();
    good_pair(mk(2, 0, 0, 0));
    send_q(mk(3, 0, 0, 0));
    send_q(~mk(3, 0, 0, 0) ^ 1);
    pulse_bus_rst();
    flags("R8 mid reset", 0, 0, 0);
    chk(out_valid == 1'b0, "R8 out_valid cleared", 32'(out_valid), 0);
    good_pair(mk(10, 0, 0, 0));
    finish_rec(AW'(9));
    cmp_rec("R8 new record");
    flags("R8 new record", 0, 0, 1);

    // R7: saturation of the node counter
    rmode = 0;
    pulse_bus_rst();
    for (int k = 0; k < (1 << NW) + 2; k++) good_pair(mk(k % 64, 0, 0, 0));
    finish_rec(AW'(10));
    cmp_rec("R7 saturate");
    flags("R7 saturate", 0, 0, (1 << NW) - 1);

    chk(stall_bad == 0, "R9 stalled word held", 32'(stall_bad), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule